// File: doc/BRIEF.md
# Chunked Parallel CRC-5 Engine

This block computes a 5-bit cyclic redundancy check with generator x^5 + x^2 + 1 (binary 100101). It takes one chunk of `N` message bits per clock, most significant bit first. Each next-state bit is an XOR of some chunk bits and some current-state bits. The block chooses those terms at elaboration time. For every chunk bit and every state bit, it runs the one-bit serial recurrence and notes which result bits change when that single term is set.

A parameter selects one of two variants:

- **Long division (augmented):** the register always holds the true remainder of the bits received so far. After the last chunk, the block feeds the five required zero bits by itself in one extra cycle.
- **Feedback (non-augmented):** the state is folded into the feedback term, so the trailing zeros are not needed. Its intermediate values differ from the division remainders, but the final CRC is the same.

The final chunk of a message may hold fewer than `N` valid bits. In that case the block applies a shorter step set that covers only the leading valid bits.

Top module: `crc5_parallel`

## Requirements
- R1: The cycle after reset is released, `crc_out` is 0 and `done` is low.
- R2: The final CRC is computed with the state starting at zero. It equals the remainder of the message followed by five zero bits, divided by 100101. Message bits are taken most significant first, and a full chunk is `chunk_data[N-1]` down to `chunk_data[0]`.
- R3: On a last chunk, `chunk_count` = k with 1 <= k <= N selects only the leading bits `chunk_data[N-1 -: k]`. The remaining low bits have no effect. A count of 0 or greater than N means N.
- R4: With `VARIANT` = 0, `crc_out` after each chunk is the long-division remainder of the bits so far. For example, the message 11011010 gives 0x04. After the last chunk the block folds in five zeros on the next cycle, and `done` rises with the result (0x14 for that message).
- R5: With `VARIANT` = 1, `crc_out` after each chunk equals the non-augmented serial feedback register. `done` rises in the cycle right after the last chunk is accepted, together with the final value of R2.
- R6: `done` is a one-cycle pulse per message, and `crc_out` keeps the final value until the next accepted chunk.
- R7: The first chunk accepted after `done` starts a new message from a zero state.
- R8: With `VARIANT` = 0, a chunk offered during the zero-folding cycle is ignored.
- R9: `crc_out` changes only when a chunk is accepted or zeros are folded in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chunk_valid | input | 1 | A chunk is offered this cycle |
| chunk_data | input | N | Chunk bits, earliest bit at the top |
| chunk_last | input | 1 | Offered chunk ends the message |
| chunk_count | input | $clog2(N+1) | Valid leading bits of a last chunk |
| crc_out | output | 5 | Registered CRC state |
| done | output | 1 | One-cycle pulse when `crc_out` is final |

## Verification
The message 11011010 pins down the remainder bit ordering against a known division: 0x04 after eight bits and 0x14 after the zeros. Messages of 1, 3 and 13 bits, with ones filling the unused low chunk bits, separate a correct partial-step selection from one that lets the unused bits leak in. Random messages of up to 64 bits run through both variants at once, and each intermediate value is compared with its own serial recurrence, which tells the two state encodings apart. A chunk offered during the folding cycle, and a last chunk sent with a zero count, cover the ignore rule and the count saturation.

// File: rtl/crc5_pkg.sv
package crc5_pkg;
  localparam int CRC_W = 5;
  // Low bits of generator 100101; the top term is implied by the shift.
  localparam logic [CRC_W-1:0] GEN_LOW = 5'h05;
  localparam int VARIANT_DIV = 0;
  localparam int VARIANT_FB  = 1;

  typedef logic [CRC_W-1:0] crc_t;

  // One long-division step: shift the bit in, subtract when the top was set.
  function automatic crc_t step_div(crc_t r, logic d);
    return {r[CRC_W-2:0], d} ^ (r[CRC_W-1] ? GEN_LOW : '0);
  endfunction

  // One feedback step: the incoming bit joins the feedback term directly.
  function automatic crc_t step_fb(crc_t r, logic d);
    logic f;
    f = r[CRC_W-1] ^ d;
    return {r[CRC_W-2:0], 1'b0} ^ (f ? GEN_LOW : '0);
  endfunction

  function automatic crc_t step(int variant, crc_t r, logic d);
    return (variant == VARIANT_FB) ? step_fb(r, d) : step_div(r, d);
  endfunction
endpackage

// File: rtl/crc5_kstep.sv
// K serial steps collapsed into one XOR matrix, built at elaboration.
module crc5_kstep
  import crc5_pkg::*;
#(
  parameter int K       = 8,
  parameter int VARIANT = VARIANT_DIV
) (
  input  crc_t         state_i,
  input  logic [K-1:0] data_i,
  output crc_t         next_o
);
  localparam int ROWS = CRC_W + K;

  function automatic crc_t run(crc_t s, logic [K-1:0] d);
    crc_t r;
    r = s;
    for (int i = K - 1; i >= 0; i--) r = step(VARIANT, r, d[i]);
    return r;
  endfunction

  // Row j < CRC_W: effect of state bit j; row CRC_W+i: effect of data bit i.
  function automatic logic [ROWS*CRC_W-1:0] build();
    logic [ROWS*CRC_W-1:0] m;
    logic [K-1:0] one;
    crc_t sone;
    m = '0;
    for (int j = 0; j < CRC_W; j++) begin
      sone = '0;
      sone[j] = 1'b1;
      m[j*CRC_W +: CRC_W] = run(sone, '0);
    end
    for (int i = 0; i < K; i++) begin
      one = '0;
      one[i] = 1'b1;
      m[(CRC_W+i)*CRC_W +: CRC_W] = run('0, one);
    end
    return m;
  endfunction

  localparam logic [ROWS*CRC_W-1:0] MAT = build();

  always_comb begin
    crc_t acc;
    acc = '0;
    for (int j = 0; j < CRC_W; j++)
      if (state_i[j]) acc = acc ^ MAT[j*CRC_W +: CRC_W];
    for (int i = 0; i < K; i++)
      if (data_i[i]) acc = acc ^ MAT[(CRC_W+i)*CRC_W +: CRC_W];
    next_o = acc;
  end
endmodule

// File: rtl/crc5_chunk_engine.sv
// One step set per possible valid length, selected by the count of a last chunk.
module crc5_chunk_engine
  import crc5_pkg::*;
#(
  parameter int N       = 8,
  parameter int VARIANT = VARIANT_DIV,
  localparam int CW     = $clog2(N + 1)
) (
  input  crc_t          base_i,
  input  logic [N-1:0]  data_i,
  input  logic          last_i,
  input  logic [CW-1:0] count_i,
  output crc_t          next_o
);
  crc_t cand [1:N];

  for (genvar k = 1; k <= N; k++) begin : g_len
    crc5_kstep #(.K(k), .VARIANT(VARIANT)) u_kstep (
      .state_i(base_i),
      .data_i (data_i[N-1 -: k]),
      .next_o (cand[k])
    );
  end

  logic [CW-1:0] use_k;

  always_comb begin
    if (!last_i || count_i == '0 || count_i > CW'(N)) use_k = CW'(N);
    else use_k = count_i;
    next_o = cand[N];
    for (int k = 1; k <= N; k++)
      if (use_k == CW'(k)) next_o = cand[k];
  end
endmodule

// File: rtl/crc5_parallel.sv
module crc5_parallel
  import crc5_pkg::*;
#(
  parameter int N       = 8,
  parameter int VARIANT = VARIANT_DIV,
  localparam int CW     = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          chunk_valid,
  input  logic [N-1:0]  chunk_data,
  input  logic          chunk_last,
  input  logic [CW-1:0] chunk_count,
  output logic [4:0]    crc_out,
  output logic          done
);
  crc_t crc_q, base, chunk_nxt, flush_nxt;
  logic done_q, flush_q, fresh_q;

  assign base = fresh_q ? '0 : crc_q;

  crc5_chunk_engine #(.N(N), .VARIANT(VARIANT)) u_engine (
    .base_i (base),
    .data_i (chunk_data),
    .last_i (chunk_last),
    .count_i(chunk_count),
    .next_o (chunk_nxt)
  );

  if (VARIANT == VARIANT_DIV) begin : g_flush
    crc5_kstep #(.K(CRC_W), .VARIANT(VARIANT_DIV)) u_zeros (
      .state_i(crc_q),
      .data_i ('0),
      .next_o (flush_nxt)
    );
  end else begin : g_noflush
    assign flush_nxt = crc_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      crc_q   <= '0;
      done_q  <= 1'b0;
      flush_q <= 1'b0;
      fresh_q <= 1'b1;
    end else begin
      done_q <= 1'b0;
      if (flush_q) begin
        crc_q   <= flush_nxt;
        done_q  <= 1'b1;
        flush_q <= 1'b0;
        fresh_q <= 1'b1;
      end else if (chunk_valid) begin
        crc_q   <= chunk_nxt;
        fresh_q <= chunk_last && (VARIANT != VARIANT_DIV);
        if (chunk_last) begin
          if (VARIANT == VARIANT_DIV) flush_q <= 1'b1;
          else done_q <= 1'b1;
        end
      end
    end
  end

  assign crc_out = crc_q;
  assign done    = done_q;
endmodule

// File: rtl/crc5_parallel_checker.sv
module crc5_parallel_checker #(
  parameter int N       = 8,
  parameter int VARIANT = 0
) (
  input logic       clk,
  input logic       rst,
  input logic       chunk_valid,
  input logic       chunk_last,
  input logic       flush_q,
  input logic [4:0] crc_out,
  input logic       done
);
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (crc_out == 5'd0 && !done));

  assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (!chunk_valid && !flush_q) |=> $stable(crc_out));

  if (VARIANT == 0) begin : g_div
    assert_last_starts_fold_R4: assert property (@(posedge clk) disable iff (rst)
      (chunk_valid && chunk_last && !flush_q) |=> (flush_q && !done));
    assert_fold_gives_done_R4: assert property (@(posedge clk) disable iff (rst)
      flush_q |=> done);
    assert_fold_single_cycle_R8: assert property (@(posedge clk) disable iff (rst)
      flush_q |=> !flush_q);
    assert_done_cause_R6: assert property (@(posedge clk) disable iff (rst)
      done |-> $past(flush_q));
  end else begin : g_fb
    assert_last_gives_done_R5: assert property (@(posedge clk) disable iff (rst)
      (chunk_valid && chunk_last) |=> done);
    assert_done_cause_R6: assert property (@(posedge clk) disable iff (rst)
      done |-> $past(chunk_valid && chunk_last));
  end
endmodule

bind crc5_parallel crc5_parallel_checker #(.N(N), .VARIANT(VARIANT)) u_checker (
  .clk        (clk),
  .rst        (rst),
  .chunk_valid(chunk_valid),
  .chunk_last (chunk_last),
  .flush_q    (flush_q),
  .crc_out    (crc_out),
  .done       (done)
);

// File: tb/crc5_parallel_bench.sv
module crc5_parallel_bench;
  localparam int N = 8;
  localparam int CW = $clog2(N + 1);
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic chunk_valid = 1'b0;
  logic [N-1:0] chunk_data = '0;
  logic chunk_last = 1'b0;
  logic [CW-1:0] chunk_count = '0;
  logic [4:0] crc_div, crc_fb;
  logic done_div, done_fb;
  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crc5_parallel #(.N(N), .VARIANT(0)) u_crc5_parallel (
    .clk(clk), .rst(rst), .chunk_valid(chunk_valid), .chunk_data(chunk_data),
    .chunk_last(chunk_last), .chunk_count(chunk_count), .crc_out(crc_div), .done(done_div));

  crc5_parallel #(.N(N), .VARIANT(1)) u_crc5_parallel_fb (
    .clk(clk), .rst(rst), .chunk_valid(chunk_valid), .chunk_data(chunk_data),
    .chunk_last(chunk_last), .chunk_count(chunk_count), .crc_out(crc_fb), .done(done_fb));

  // Bit i of a message (i = 0 first) sits at m[len-1-i].
  function automatic logic [4:0] ref_div(logic [63:0] m, int len, int upto, bit zeros);
    logic [4:0] r = '0;
    for (int i = 0; i < upto; i++) r = {r[3:0], m[len-1-i]} ^ (r[4] ? 5'h05 : 5'h00);
    if (zeros) for (int i = 0; i < 5; i++) r = {r[3:0], 1'b0} ^ (r[4] ? 5'h05 : 5'h00);
    return r;
  endfunction

  function automatic logic [4:0] ref_fb(logic [63:0] m, int len, int upto);
    logic [4:0] r = '0;
    for (int i = 0; i < upto; i++) r = {r[3:0], 1'b0} ^ ((r[4] ^ m[len-1-i]) ? 5'h05 : 5'h00);
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  function automatic logic [N-1:0] chunk_of(logic [63:0] m, int len, int c, int k);
    logic [N-1:0] d = '1;  // unused low bits filled with ones
    for (int j = 0; j < k; j++) d[N-1-j] = m[len-1-(c*N+j)];
    return d;
  endfunction

  // Sends a whole message and checks intermediates and finals of both variants.
  task automatic send_msg(input logic [63:0] m, input int len, input bit zcount, input bit junk_in_fold);
    int nch = (len + N - 1) / N;
    logic [4:0] fin = ref_div(m, len, len, 1'b1);
    logic [N-1:0] junk = N'(8'hA7);
    for (int c = 0; c < nch; c++) begin
      int k = (c == nch - 1) ? len - c * N : N;
      @(negedge clk);
      chunk_valid = 1'b1;
      chunk_data  = chunk_of(m, len, c, k);
      chunk_last  = (c == nch - 1);
      chunk_count = (zcount && k == N) ? '0 : CW'(k);
      @(negedge clk);
      chunk_valid = 1'b0;
      chunk_last  = 1'b0;
      if (c != nch - 1) begin
        chk(crc_div == ref_div(m, len, (c+1)*N, 1'b0), "R4", "div intermediate", crc_div, ref_div(m, len, (c+1)*N, 1'b0));
        chk(crc_fb == ref_fb(m, len, (c+1)*N), "R5", "fb intermediate", crc_fb, ref_fb(m, len, (c+1)*N));
      end else begin
        chk(done_fb == 1'b1, "R5", "fb done after last", done_fb, 1);
        chk(crc_fb == fin, "R2", "fb final (R3 partial)", crc_fb, fin);
        chk(done_div == 1'b0, "R4", "div done during fold", done_div, 0);
        if (junk_in_fold) begin
          chunk_valid = 1'b1;
          chunk_data  = junk;
          chunk_last  = 1'b1;
          chunk_count = CW'(N);
        end
      end
    end
    @(negedge clk);
    chunk_valid = 1'b0;
    chunk_last  = 1'b0;
    chk(done_div == 1'b1, "R4", "div done after fold", done_div, 1);
    chk(crc_div == fin, "R2", "div final (R3 partial, R8 ignore)", crc_div, fin);
    if (junk_in_fold) begin
      chk(crc_fb == ref_div(64'(junk), N, N, 1'b1), "R7", "fb fresh message", crc_fb, ref_div(64'(junk), N, N, 1'b1));
    end else begin
      chk(done_fb == 1'b0, "R6", "fb done single pulse", done_fb, 0);
      chk(crc_fb == fin, "R6", "fb final held", crc_fb, fin);
    end
    @(negedge clk);
    chk(done_div == 1'b0, "R6", "div done single pulse", done_div, 0);
    chk(crc_div == fin, "R9", "div held while idle", crc_div, fin);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(crc_div == 5'd0 && !done_div, "R1", "div reset state", {done_div, crc_div}, 0);
    chk(crc_fb == 5'd0 && !done_fb, "R1", "fb reset state", {done_fb, crc_fb}, 0);
  endtask

  task automatic t_known();
    @(negedge clk);
    chunk_valid = 1'b1;
    chunk_data  = 8'b11011010;
    chunk_last  = 1'b1;
    chunk_count = CW'(N);
    @(negedge clk);
    chunk_valid = 1'b0;
    chunk_last  = 1'b0;
    chk(crc_div == 5'h04, "R4", "known remainder before zeros", crc_div, 5'h04);
    chk(crc_fb == 5'h14, "R5", "known fb result", crc_fb, 5'h14);
    @(negedge clk);
    chk(crc_div == 5'h14 && done_div, "R4", "known final with zeros", crc_div, 5'h14);
  endtask

  task automatic t_partial();
    send_msg(64'h5, 3, 1'b0, 1'b0);       // R3 three valid bits
    send_msg(64'h1, 1, 1'b0, 1'b0);       // R3 single bit
    send_msg(64'h1B35, 13, 1'b0, 1'b0);   // R3 full chunk then five bits
  endtask

  task automatic t_zero_count();
    send_msg(64'hC3E1, 16, 1'b1, 1'b0);   // R3 count 0 means N
  endtask

  task automatic t_fold_ignore();
    send_msg(64'h2D7, 10, 1'b0, 1'b1);    // R8 chunk during fold, R7 fresh start
  endtask

  task automatic t_random();
    for (int n = 0; n < 25; n++) begin
      int len = 1 + int'($urandom % 64);
      logic [63:0] m = {$urandom, $urandom};
      send_msg(m, len, 1'b0, 1'b0);       // R2 R4 R5 R7 across random messages
    end
  endtask

  initial begin
    void'($urandom(32'd91));
    t_reset();
    t_known();
    t_partial();
    t_zero_count();
    t_fold_ignore();
    t_random();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finished");
    finish_run();
  end
endmodule